// File: doc/BRIEF.md
# SR-IOV Capability Register Block

This block holds the SR-IOV extended capability registers of one physical function and drives the enables of a fixed array of virtual functions. Software reaches the registers through a dword-addressed configuration port with byte enables. Each register byte has a write mask, and a write merges new data only into the bits that the mask allows. The Control and NumVFs registers change each other's masks. While VFs are enabled, the VF count cannot be changed. VF Enable can only be set while the programmed count fits within the fixed VF total.

The side effects of a Control or NumVFs write run one clock after the write is stored: the VF enable vector updates and both masks are recomputed. The block also reports how many VFs are active and answers a registered lookup from VF index to routing ID (device/function number). TotalVFs, First VF Offset, VF Stride and the PF's own routing ID are elaboration parameters. If the last VF's routing ID would fall outside the 8-bit space, elaboration fails.

Top module: `sriov_cap_ctrl`

## Requirements
- R1: Control bit positions are VF Enable at bit 0, Memory Space Enable at bit 3 and ARI Capable Hierarchy at bit 4. A write that stores Control (dword 0, byte enable 0) with VF Enable set turns on VFs 0..NumVFs-1 one clock later. The VF enable vector is always a contiguous run starting at bit 0.
- R2: While VFs are enabled, the NumVFs write mask is zero, and writes to NumVFs leave it unchanged.
- R3: A stored Control write with VF Enable clear turns every VF off one clock later and restores the NumVFs write mask to 0xFFFF.
- R4: After a NumVFs write (byte enable 2 or 3 without byte enable 0), the Control write mask becomes MSE|ARI. VF Enable is added to the mask only when NumVFs <= TotalVFs. Control bits outside the mask always read 0.
- R5: When one write stores both Control and NumVFs, NumVFs takes the new value, the Control side effects run, and the Control mask is not recomputed.
- R6: The active VF count equals NumVFs while stored VF Enable is 1, and is 0 otherwise.
- R7: A lookup returns, one clock later, valid = index < active count and index < TotalVFs. When valid, the routing ID is PF_DEVFN + VF_OFFSET + index*VF_STRIDE.
- R8: System Page Size (dword 3) resets to 0x1 and only bits under the mask 0x553 are writable.
- R9: Dword 0 holds Control in [15:0] and NumVFs in [31:16]. Dword 1 holds TotalVFs in [15:0] and VF Stride in [31:16]. Dword 2 holds VF Offset in [15:0]. Dword 4 is the VF identity word, 0xFFFFFFFF. Dwords 1, 2 and 4 are read-only, other dwords read 0, and read data appears one clock after rd_en.
- R10: Reset clears Control, NumVFs and the VF enables, and leaves VF Enable, MSE and ARI writable in Control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| vf_en | output | TOTAL_VFS | Per-VF enable, registered |
| vf_count | output | 16 | Number of active VFs |
| lk_idx | input | IDX_W | VF index to look up |
| lk_valid | output | 1 | Looked-up VF exists and is active |
| lk_rid | output | 8 | Routing ID of the looked-up VF |

## Verification
The assertions check on every cycle that the enable vector is a contiguous run from bit 0 and that NumVFs is locked while any VF is on. They also check that VF Enable cannot rise while its mask bit is clear, that page-size bits outside the mask stay zero, and that a valid lookup stays inside the routing-ID window. The bench scenarios are needed to show the sequences: enable, lock, disable, overflow refusal, the priority of a combined write, the exact routing IDs at the edge indices, and the state after a reset in mid-operation.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;

  // Control register bit positions
  localparam int CTL_VFE = 0;
  localparam int CTL_MSE = 3;
  localparam int CTL_ARI = 4;

  localparam logic [15:0] CTL_MASK_BASE = 16'h0018;
  localparam logic [15:0] CTL_MASK_FULL = 16'h0019;

  localparam logic [31:0] PAGE_WMASK = 32'h0000_0553;
  localparam logic [31:0] PAGE_RESET = 32'h0000_0001;
  localparam logic [31:0] VF_IDENT   = 32'hFFFF_FFFF;

  // dword map
  localparam int DW_CTRL  = 0;
  localparam int DW_GEOM  = 1;
  localparam int DW_OFFS  = 2;
  localparam int DW_PAGE  = 3;
  localparam int DW_IDENT = 4;

  function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                          input logic [15:0] new_v,
                                          input logic [15:0] wmask,
                                          input logic [1:0]  be);
    logic [15:0] m;
    m = wmask & {{8{be[1]}}, {8{be[0]}}};
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/sriov_regfile.sv
module sriov_regfile
  import sriov_cap_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int TOTAL_VFS = 8,
  parameter int VF_OFFSET = 4,
  parameter int VF_STRIDE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  logic [15:0]       ctrl_wmask,
  input  logic [15:0]       num_wmask,
  output logic [31:0]       rdata,
  output logic [15:0]       ctrl_q,
  output logic [15:0]       num_q,
  output logic              ctrl_evt,
  output logic              num_evt
);

  localparam logic [15:0] TOTAL_W  = 16'(TOTAL_VFS);
  localparam logic [15:0] OFFSET_W = 16'(VF_OFFSET);
  localparam logic [15:0] STRIDE_W = 16'(VF_STRIDE);

  logic [31:0] page_q;
  logic        hit_ctrl, hit_page;
  logic [31:0] page_m;

  assign hit_ctrl = wr_en && (int'(addr) == DW_CTRL);
  assign hit_page = wr_en && (int'(addr) == DW_PAGE);
  assign page_m   = PAGE_WMASK & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      num_q    <= '0;
      page_q   <= PAGE_RESET;
      ctrl_evt <= 1'b0;
      num_evt  <= 1'b0;
    end else begin
      ctrl_evt <= hit_ctrl && be[0];
      num_evt  <= hit_ctrl && (be[2] || be[3]) && !be[0];
      if (hit_ctrl) begin
        ctrl_q <= merge16(ctrl_q, wdata[15:0],  ctrl_wmask, be[1:0]);
        num_q  <= merge16(num_q,  wdata[31:16], num_wmask,  be[3:2]);
      end
      if (hit_page) begin
        page_q <= (page_q & ~page_m) | (wdata & page_m);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (int'(addr))
        DW_CTRL:  rdata <= {num_q, ctrl_q};
        DW_GEOM:  rdata <= {STRIDE_W, TOTAL_W};
        DW_OFFS:  rdata <= {16'h0000, OFFSET_W};
        DW_PAGE:  rdata <= page_q;
        DW_IDENT: rdata <= VF_IDENT;
        default:  rdata <= '0;
      endcase
    end
  end

  // R2
  num_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (num_wmask == 16'h0000) |=> $stable(num_q));

  // R4
  vfe_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wmask[CTL_VFE] |=> !$rose(ctrl_q[CTL_VFE]));

  // R8
  page_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (page_q & ~PAGE_WMASK) == 32'h0);

endmodule

// File: rtl/sriov_vf_ctrl.sv
module sriov_vf_ctrl
  import sriov_cap_pkg::*;
#(
  parameter int TOTAL_VFS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctrl_evt,
  input  logic                 num_evt,
  input  logic                 vfe,
  input  logic [15:0]          num_q,
  output logic [TOTAL_VFS-1:0] vf_en,
  output logic [15:0]          ctrl_wmask,
  output logic [15:0]          num_wmask
);

  localparam logic [15:0] TOTAL_W = 16'(TOTAL_VFS);

  for (genvar i = 0; i < TOTAL_VFS; i++) begin : g_vf
    always_ff @(posedge clk) begin
      if (rst) begin
        vf_en[i] <= 1'b0;
      end else if (ctrl_evt) begin
        vf_en[i] <= vfe && (16'(i) < num_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_wmask  <= 16'hFFFF;
      ctrl_wmask <= CTL_MASK_FULL;
    end else if (ctrl_evt) begin
      num_wmask <= vfe ? 16'h0000 : 16'hFFFF;
    end else if (num_evt) begin
      ctrl_wmask <= (num_q <= TOTAL_W) ? CTL_MASK_FULL : CTL_MASK_BASE;
    end
  end

  // R2
  lock_while_on_chk: assert property (@(posedge clk) disable iff (rst)
    (|vf_en) |-> (num_wmask == 16'h0000));

  // R3
  off_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_evt && !vfe) |=> (vf_en == '0) && (num_wmask == 16'hFFFF));

endmodule

// File: rtl/sriov_rid_lookup.sv
module sriov_rid_lookup #(
  parameter int TOTAL_VFS = 8,
  parameter int PF_DEVFN  = 16,
  parameter int VF_OFFSET = 4,
  parameter int VF_STRIDE = 2,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      count,
  output logic             valid,
  output logic [7:0]       rid
);

  localparam int RID_FIRST = PF_DEVFN + VF_OFFSET;
  localparam int RID_LAST  = RID_FIRST + (TOTAL_VFS - 1) * VF_STRIDE;

  int rid_calc;
  assign rid_calc = RID_FIRST + int'(idx) * VF_STRIDE;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      rid   <= '0;
    end else begin
      valid <= (16'(idx) < count) && (int'(idx) < TOTAL_VFS);
      rid   <= 8'(rid_calc);
    end
  end

  // R7
  rid_window_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rid >= 8'(RID_FIRST)) && (rid <= 8'(RID_LAST)));

endmodule

// File: rtl/sriov_cap_ctrl.sv
module sriov_cap_ctrl
  import sriov_cap_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int TOTAL_VFS = 8,
  parameter int PF_DEVFN  = 16,
  parameter int VF_OFFSET = 4,
  parameter int VF_STRIDE = 2,
  parameter int IDX_W     = $clog2(TOTAL_VFS) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic [TOTAL_VFS-1:0] vf_en,
  output logic [15:0]          vf_count,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic                 lk_valid,
  output logic [7:0]           lk_rid
);

  localparam int LAST_RID = PF_DEVFN + VF_OFFSET + (TOTAL_VFS - 1) * VF_STRIDE;

  if (TOTAL_VFS < 1 || LAST_RID >= 256) begin : g_bad_geometry
    $error("sriov_cap_ctrl: VF routing IDs exceed the 8-bit space");
  end

  logic [15:0] ctrl_q, num_q, ctrl_wmask, num_wmask;
  logic        ctrl_evt, num_evt;

  sriov_regfile #(
    .ADDR_W(ADDR_W), .TOTAL_VFS(TOTAL_VFS),
    .VF_OFFSET(VF_OFFSET), .VF_STRIDE(VF_STRIDE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .rd_en(cfg_rd), .addr(cfg_addr),
    .be(cfg_be), .wdata(cfg_wdata), .ctrl_wmask(ctrl_wmask),
    .num_wmask(num_wmask), .rdata(cfg_rdata), .ctrl_q(ctrl_q),
    .num_q(num_q), .ctrl_evt(ctrl_evt), .num_evt(num_evt)
  );

  sriov_vf_ctrl #(.TOTAL_VFS(TOTAL_VFS)) u_vfctl (
    .clk(clk), .rst(rst), .ctrl_evt(ctrl_evt), .num_evt(num_evt),
    .vfe(ctrl_q[CTL_VFE]), .num_q(num_q), .vf_en(vf_en),
    .ctrl_wmask(ctrl_wmask), .num_wmask(num_wmask)
  );

  assign vf_count = ctrl_q[CTL_VFE] ? num_q : 16'h0000;

  sriov_rid_lookup #(
    .TOTAL_VFS(TOTAL_VFS), .PF_DEVFN(PF_DEVFN), .VF_OFFSET(VF_OFFSET),
    .VF_STRIDE(VF_STRIDE), .IDX_W(IDX_W)
  ) u_lookup (
    .clk(clk), .rst(rst), .idx(lk_idx), .count(vf_count),
    .valid(lk_valid), .rid(lk_rid)
  );

  // R1
  contiguous_en_chk: assert property (@(posedge clk) disable iff (rst)
    ((vf_en + 1'b1) & vf_en) == '0);

endmodule

// File: tb/sriov_cap_ctrl_bench.sv
module sriov_cap_ctrl_bench;

  localparam int TOTAL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [TOTAL-1:0] vf_en;
  logic [15:0] vf_count;
  logic [3:0]  lk_idx = '0;
  logic        lk_valid;
  logic [7:0]  lk_rid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  sriov_cap_ctrl u_sriov_cap_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .vf_en(vf_en), .vf_count(vf_count),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_rid(lk_rid)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [3:0] b,
                           input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = b; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic lookup(input logic [3:0] i, input logic exp_v,
                        input logic [7:0] exp_rid);
    @(negedge clk);
    lk_idx = i;
    @(negedge clk);
    check("R7 valid", {31'h0, lk_valid}, {31'h0, exp_v});
    if (exp_v) check("R7 rid", {24'h0, lk_rid}, {24'h0, exp_rid});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R10 vf_en", 32'(vf_en), 32'h0);
    check("R10 count", 32'(vf_count), 32'h0);
    cfg_read(3'd0, d); check("R10 dw0", d, 32'h0);
    cfg_read(3'd1, d); check("R9 geom", d, 32'h0002_0008);
    cfg_read(3'd2, d); check("R9 offset", d, 32'h0000_0004);
    cfg_read(3'd3, d); check("R8 page reset", d, 32'h0000_0001);
    cfg_read(3'd4, d); check("R9 ident", d, 32'hFFFF_FFFF);
    cfg_read(3'd6, d); check("R9 unmapped", d, 32'h0);
  endtask

  task automatic t_enable_three();
    logic [31:0] d;
    cfg_write(3'd0, 4'b1100, 32'h0003_0000);
    cfg_write(3'd0, 4'b0001, 32'h0000_0019);
    check("R1 vf_en", 32'(vf_en), 32'h07);
    check("R6 count", 32'(vf_count), 32'd3);
    cfg_read(3'd0, d); check("R1 dw0", d, 32'h0003_0019);
    lookup(4'd2, 1'b1, 8'h18);
    lookup(4'd3, 1'b0, 8'h00);
  endtask

  task automatic t_num_locked();
    logic [31:0] d;
    cfg_write(3'd0, 4'b1100, 32'h0005_0000);
    cfg_read(3'd0, d); check("R2 num locked", d, 32'h0003_0019);
    check("R2 vf_en", 32'(vf_en), 32'h07);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    cfg_write(3'd0, 4'b0001, 32'h0000_0018);
    check("R3 vf_en off", 32'(vf_en), 32'h0);
    cfg_write(3'd0, 4'b1100, 32'h0006_0000);
    cfg_read(3'd0, d); check("R3 num unlocked", d, 32'h0006_0018);
    check("R6 count zero", 32'(vf_count), 32'h0);
  endtask

  task automatic t_overflow_refused();
    logic [31:0] d;
    cfg_write(3'd0, 4'b1100, 32'h0009_0000);
    cfg_write(3'd0, 4'b0011, 32'h0000_FFFF);
    cfg_read(3'd0, d); check("R4 vfe refused", d, 32'h0009_0018);
    check("R4 vf_en", 32'(vf_en), 32'h0);
    check("R4 count", 32'(vf_count), 32'h0);
  endtask

  task automatic t_full_enable();
    cfg_write(3'd0, 4'b1100, 32'h0008_0000);
    cfg_write(3'd0, 4'b0001, 32'h0000_0019);
    check("R1 all on", 32'(vf_en), 32'hFF);
    check("R6 count 8", 32'(vf_count), 32'd8);
    lookup(4'd0, 1'b1, 8'h14);
    lookup(4'd7, 1'b1, 8'h22);
    lookup(4'd8, 1'b0, 8'h00);
  endtask

  task automatic t_combined();
    cfg_write(3'd0, 4'b0001, 32'h0000_0018);
    check("R3 off again", 32'(vf_en), 32'h0);
    cfg_write(3'd0, 4'b1111, 32'h0002_0019);
    check("R5 vf_en", 32'(vf_en), 32'h03);
    check("R5 count", 32'(vf_count), 32'd2);
  endtask

  task automatic t_page_and_ro();
    logic [31:0] d;
    cfg_write(3'd3, 4'b1111, 32'hFFFF_FFFF);
    cfg_read(3'd3, d); check("R8 page mask", d, 32'h0000_0553);
    cfg_write(3'd3, 4'b0001, 32'h0000_0000);
    cfg_read(3'd3, d); check("R8 page byte", d, 32'h0000_0500);
    cfg_write(3'd1, 4'b1111, 32'hFFFF_FFFF);
    cfg_read(3'd1, d); check("R9 geom ro", d, 32'h0002_0008);
    cfg_write(3'd4, 4'b1111, 32'h0);
    cfg_read(3'd4, d); check("R9 ident ro", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset_midway();
    logic [31:0] d;
    do_reset();
    check("R10 vf_en cleared", 32'(vf_en), 32'h0);
    cfg_read(3'd0, d); check("R10 dw0 cleared", d, 32'h0);
    cfg_write(3'd0, 4'b0001, 32'h0000_0001);
    cfg_read(3'd0, d); check("R10 vfe writable", d, 32'h0000_0001);
    check("R6 count num0", 32'(vf_count), 32'h0);
    check("R1 none on", 32'(vf_en), 32'h0);
  endtask

  initial begin
    t_reset_state();
    t_enable_three();
    t_num_locked();
    t_disable();
    t_overflow_refused();
    t_full_enable();
    t_combined();
    t_page_and_ro();
    t_reset_midway();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule